// File: doc/BRIEF.md
# Sign-Extending Halfword Load Unit

This block carries out one load instruction at a time from the signed-halfword family of a 32-bit big-endian instruction set. There are four addressing variants: base plus immediate, base plus immediate with base update, base plus index register, and base plus index register with base update. The block decodes the instruction word. In the same cycle it reads the base and index registers through two combinational read ports of a 32-entry register file. It registers the effective address and sends one byte-addressed read to memory through a request/response handshake.

The memory returns two bytes. The block widens the halfword to the full register width, with the sign kept. It then drives a single register write port. The destination is always written first. For update variants, a second write follows in the next cycle and stores the effective address into the base register. A word outside the four encodings raises a one-cycle illegal flag and touches neither memory nor registers.

Top module: `sxh_load_unit`

## Requirements
- R1: Primary opcode 42 (instruction bits [31:26]) selects base plus 16-bit signed immediate. Primary opcode 43 selects the same with base update. The destination is in bits [25:21], the base in bits [20:16] and the immediate in bits [15:0].
- R2: Primary opcode 31 with extended opcode 343 in bits [10:1] selects base plus index. Extended opcode 375 selects base plus index with update. The index register is in bits [15:11]. Bit [0] has no effect.
- R3: The effective address is the base plus either the sign-extended immediate or the index value, summed at 64 bits with wraparound. Only the low 32 bits are kept and presented on `mem_addr_o`.
- R4: In the two non-update variants, a base field of 0 contributes the value zero. The update variants read register 0 like any other register.
- R5: `mem_rdata_i[15:8]` is the byte at the effective address and forms the upper half of the loaded halfword. `mem_rdata_i[7:0]` is the byte at the address plus one.
- R6: The destination receives the halfword sign-extended to 64 bits.
- R7: Update variants write the 32-bit effective address, zero-extended to 64 bits, into the base register.
- R8: The destination write occurs one cycle before the base write. When both name the same register, that register ends up holding the address.
- R9: Odd effective addresses are requested unchanged, and no fault is raised.
- R10: For any other instruction word, `illegal_o` pulses in the cycle after `start_i`. No memory request and no register write occur.
- R11: `mem_req_o` stays high with a stable address until `mem_rvalid_i`. The destination write follows in the next cycle. `done_o` accompanies the last write of the instruction. `start_i` has no effect while an instruction is in flight.
- R12: While `rst_n` is low and after it is released, `mem_req_o`, `rf_we_o`, `done_o` and `illegal_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Begin the instruction on `instr_i` (taken only when idle) |
| instr_i | input | 32 | Instruction word |
| rf_rd_a_addr_o | output | 5 | Base register read address |
| rf_rd_a_data_i | input | 64 | Base register read data (combinational) |
| rf_rd_b_addr_o | output | 5 | Index register read address |
| rf_rd_b_data_i | input | 64 | Index register read data (combinational) |
| mem_req_o | output | 1 | Memory read request, held until response |
| mem_addr_o | output | 32 | Byte address of the halfword |
| mem_rvalid_i | input | 1 | Memory response valid |
| mem_rdata_i | input | 16 | Returned bytes, byte at address in [15:8] |
| rf_we_o | output | 1 | Register write enable |
| rf_waddr_o | output | 5 | Register write address |
| rf_wdata_o | output | 64 | Register write data |
| done_o | output | 1 | Last write of the instruction is presented |
| illegal_o | output | 1 | Unrecognised instruction word |

## Verification
The bench builds the unit with its default widths: 64-bit registers and a 32-bit memory address. With these widths, a base near 2^33 plus a small index exercises the cut of the 64-bit sum down to 32 bits. A register holding all ones minus one drives the immediate and index paths through a negative offset. The register file in the bench is a live array, so update variants and the base-equals-destination collision are judged by the value that finally sits in the register.

// File: rtl/sxh_pkg.sv
// Shared encodings and types for the signed-halfword load unit.
// Assumes the fixed 32-bit instruction layout with 5-bit register fields.
package sxh_pkg;
    localparam int REG_IDX_W = 5;
    localparam int HALF_W    = 16;

    localparam logic [5:0] OPC_DISP     = 6'd42;
    localparam logic [5:0] OPC_DISP_UPD = 6'd43;
    localparam logic [5:0] OPC_EXT      = 6'd31;
    localparam logic [9:0] XO_IDX       = 10'd343;
    localparam logic [9:0] XO_IDX_UPD   = 10'd375;

    typedef struct packed {
        logic                 legal;
        logic                 upd;
        logic                 idx;
        logic [REG_IDX_W-1:0] rt;
        logic [REG_IDX_W-1:0] ra;
        logic [REG_IDX_W-1:0] rb;
        logic [HALF_W-1:0]    disp;
    } sxh_dec_t;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_MEM  = 2'd1,
        S_WBD  = 2'd2,
        S_WBB  = 2'd3
    } sxh_state_e;
endpackage

// File: rtl/sxh_decode.sv
// Instruction decoder: splits the word into register fields and flags the
// four recognised encodings. Purely combinational; the record bit is dropped.
module sxh_decode
    import sxh_pkg::*;
(
    input  logic [31:0] instr_i,
    output sxh_dec_t    dec_o
);
    logic unused_rc;
    assign unused_rc = instr_i[0];

    // Field extraction and encoding match
    always_comb begin
        dec_o       = '0;
        dec_o.rt    = instr_i[25:21];
        dec_o.ra    = instr_i[20:16];
        dec_o.rb    = instr_i[15:11];
        dec_o.disp  = instr_i[15:0];
        case (instr_i[31:26])
            OPC_DISP:     dec_o.legal = 1'b1;
            OPC_DISP_UPD: begin
                dec_o.legal = 1'b1;
                dec_o.upd   = 1'b1;
            end
            OPC_EXT: begin
                if (instr_i[10:1] == XO_IDX) begin
                    dec_o.legal = 1'b1;
                    dec_o.idx   = 1'b1;
                end else if (instr_i[10:1] == XO_IDX_UPD) begin
                    dec_o.legal = 1'b1;
                    dec_o.idx   = 1'b1;
                    dec_o.upd   = 1'b1;
                end
            end
            default: dec_o.legal = 1'b0;
        endcase
    end
endmodule

// File: rtl/sxh_agen.sv
// Effective-address generator: base (or zero) plus sign-extended immediate
// or index, summed at XLEN bits and cut to AW bits. Assumes AW <= XLEN.
module sxh_agen #(
    parameter int XLEN = 64,
    parameter int AW   = 32
) (
    input  logic            upd_i,
    input  logic            idx_i,
    input  logic            ra_zero_i,
    input  logic [15:0]     disp_i,
    input  logic [XLEN-1:0] base_i,
    input  logic [XLEN-1:0] index_i,
    output logic [AW-1:0]   ea_o
);
    localparam int DEXT = XLEN - 16;

    logic [XLEN-1:0] base_eff;
    logic [XLEN-1:0] offset;
    logic [XLEN-1:0] sum;
    logic            unused_hi;

    // Operand selection with the zero-base rule for non-update forms
    always_comb begin
        base_eff = (ra_zero_i && !upd_i) ? '0 : base_i;
        offset   = idx_i ? index_i : {{DEXT{disp_i[15]}}, disp_i};
        sum      = base_eff + offset;
    end

    assign ea_o      = sum[AW-1:0];
    assign unused_hi = ^sum;
endmodule

// File: rtl/sxh_seq.sv
// Sequencer: holds the memory request, captures the halfword, then issues
// the destination write and, for update forms, the base write one cycle later.
// Assumes the register file commits one write per cycle in issue order.
module sxh_seq
    import sxh_pkg::*;
#(
    parameter int XLEN = 64,
    parameter int AW   = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_i,
    input  logic                 legal_i,
    input  logic                 upd_i,
    input  logic [REG_IDX_W-1:0] rt_i,
    input  logic [REG_IDX_W-1:0] ra_i,
    input  logic [AW-1:0]        ea_i,
    output logic                 mem_req_o,
    output logic [AW-1:0]        mem_addr_o,
    input  logic                 mem_rvalid_i,
    input  logic [HALF_W-1:0]    mem_rdata_i,
    output logic                 rf_we_o,
    output logic [REG_IDX_W-1:0] rf_waddr_o,
    output logic [XLEN-1:0]      rf_wdata_o,
    output logic                 done_o,
    output logic                 illegal_o
);
    localparam int SEXT_W = XLEN - HALF_W;
    localparam int ZEXT_W = XLEN - AW;

    sxh_state_e           state_q;
    logic                 upd_q;
    logic [REG_IDX_W-1:0] rt_q;
    logic [REG_IDX_W-1:0] ra_q;
    logic [AW-1:0]        ea_q;
    logic [HALF_W-1:0]    half_q;
    logic                 ill_q;

    // State, captured operands and the illegal pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            upd_q   <= 1'b0;
            rt_q    <= '0;
            ra_q    <= '0;
            ea_q    <= '0;
            half_q  <= '0;
            ill_q   <= 1'b0;
        end else begin
            ill_q <= (state_q == S_IDLE) && start_i && !legal_i;
            case (state_q)
                S_IDLE: if (start_i && legal_i) begin
                    state_q <= S_MEM;
                    upd_q   <= upd_i;
                    rt_q    <= rt_i;
                    ra_q    <= ra_i;
                    ea_q    <= ea_i;
                end
                S_MEM: if (mem_rvalid_i) begin
                    half_q  <= mem_rdata_i;
                    state_q <= S_WBD;
                end
                S_WBD:   state_q <= upd_q ? S_WBB : S_IDLE;
                default: state_q <= S_IDLE;
            endcase
        end
    end

    // Output decode from the current state
    always_comb begin
        mem_req_o  = (state_q == S_MEM);
        mem_addr_o = ea_q;
        rf_we_o    = (state_q == S_WBD) || (state_q == S_WBB);
        rf_waddr_o = (state_q == S_WBB) ? ra_q : rt_q;
        rf_wdata_o = (state_q == S_WBB) ? {{ZEXT_W{1'b0}}, ea_q}
                                        : {{SEXT_W{half_q[HALF_W-1]}}, half_q};
        done_o     = (state_q == S_WBB) || ((state_q == S_WBD) && !upd_q);
        illegal_o  = ill_q;
    end

    assert_ill_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE && start_i && !legal_i) |=> (illegal_o && !mem_req_o && !rf_we_o));

    assert_req_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !mem_rvalid_i) |=> (mem_req_o && $stable(mem_addr_o)));

    assert_wb_after_resp_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && mem_rvalid_i) |=> (rf_we_o && rf_wdata_o[HALF_W-1:0] == $past(mem_rdata_i)));

    assert_sext_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_we_o && $past(mem_rvalid_i) && $past(mem_req_o))
            |-> (rf_wdata_o[XLEN-1:HALF_W] == {SEXT_W{rf_wdata_o[HALF_W-1]}}));

    assert_base_last_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_we_o && !done_o) |=> (rf_we_o && done_o && rf_wdata_o[XLEN-1:AW] == '0));

    assert_done_we_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> rf_we_o);
endmodule

// File: rtl/sxh_load_unit.sv
// Top of the signed-halfword load unit: decode, address generation and the
// request/writeback sequencer. Register reads are combinational in the start
// cycle; one instruction is in flight at a time.
module sxh_load_unit
    import sxh_pkg::*;
#(
    parameter int XLEN = 64,
    parameter int AW   = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_i,
    input  logic [31:0]          instr_i,
    output logic [REG_IDX_W-1:0] rf_rd_a_addr_o,
    input  logic [XLEN-1:0]      rf_rd_a_data_i,
    output logic [REG_IDX_W-1:0] rf_rd_b_addr_o,
    input  logic [XLEN-1:0]      rf_rd_b_data_i,
    output logic                 mem_req_o,
    output logic [AW-1:0]        mem_addr_o,
    input  logic                 mem_rvalid_i,
    input  logic [HALF_W-1:0]    mem_rdata_i,
    output logic                 rf_we_o,
    output logic [REG_IDX_W-1:0] rf_waddr_o,
    output logic [XLEN-1:0]      rf_wdata_o,
    output logic                 done_o,
    output logic                 illegal_o
);
    sxh_dec_t      dec;
    logic [AW-1:0] ea;

    sxh_decode u_dec (
        .instr_i (instr_i),
        .dec_o   (dec)
    );

    assign rf_rd_a_addr_o = dec.ra;
    assign rf_rd_b_addr_o = dec.rb;

    sxh_agen #(.XLEN(XLEN), .AW(AW)) u_agen (
        .upd_i     (dec.upd),
        .idx_i     (dec.idx),
        .ra_zero_i (dec.ra == '0),
        .disp_i    (dec.disp),
        .base_i    (rf_rd_a_data_i),
        .index_i   (rf_rd_b_data_i),
        .ea_o      (ea)
    );

    sxh_seq #(.XLEN(XLEN), .AW(AW)) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .legal_i      (dec.legal),
        .upd_i        (dec.upd),
        .rt_i         (dec.rt),
        .ra_i         (dec.ra),
        .ea_i         (ea),
        .mem_req_o    (mem_req_o),
        .mem_addr_o   (mem_addr_o),
        .mem_rvalid_i (mem_rvalid_i),
        .mem_rdata_i  (mem_rdata_i),
        .rf_we_o      (rf_we_o),
        .rf_waddr_o   (rf_waddr_o),
        .rf_wdata_o   (rf_wdata_o),
        .done_o       (done_o),
        .illegal_o    (illegal_o)
    );

    assert_quiet_reset_R12: assert property (@(posedge clk)
        !rst_n |=> (!mem_req_o && !rf_we_o && !done_o && !illegal_o));
endmodule

// File: tb/sxh_load_unit_bench.sv
// Self-checking bench: a vector table walked by one loop, then directed
// tests for ignored start, reset in flight and reset state.
module sxh_load_unit_bench;
    localparam int XLEN = 64;
    localparam int AW   = 32;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            start = 1'b0;
    logic [31:0]     instr = '0;
    logic [4:0]      ra_addr, rb_addr, waddr;
    logic [XLEN-1:0] ra_data, rb_data, wdata;
    logic            mem_req, rvalid = 1'b0, we, done, illegal;
    logic [AW-1:0]   mem_addr;
    logic [15:0]     rdata = '0;
    logic [XLEN-1:0] rf [0:31];
    int              n_run = 0, n_fail = 0;
    bit              finished = 0;

    always #5 clk = ~clk;

    sxh_load_unit #(.XLEN(XLEN), .AW(AW)) u_sxh_load_unit (
        .clk(clk), .rst_n(rst_n), .start_i(start), .instr_i(instr),
        .rf_rd_a_addr_o(ra_addr), .rf_rd_a_data_i(ra_data),
        .rf_rd_b_addr_o(rb_addr), .rf_rd_b_data_i(rb_data),
        .mem_req_o(mem_req), .mem_addr_o(mem_addr),
        .mem_rvalid_i(rvalid), .mem_rdata_i(rdata),
        .rf_we_o(we), .rf_waddr_o(waddr), .rf_wdata_o(wdata),
        .done_o(done), .illegal_o(illegal)
    );

    assign ra_data = rf[ra_addr];
    assign rb_data = rf[rb_addr];

    // Register file model: preset in reset, written by the unit otherwise
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 32; i++) begin
                case (i)
                    0:       rf[i] <= 64'h0000_0000_0000_5000;
                    3:       rf[i] <= 64'hFFFF_FFFF_FFFF_FFFE;
                    4:       rf[i] <= 64'h0000_0001_FFFF_FFFF;
                    5:       rf[i] <= 64'd3;
                    default: rf[i] <= 64'h0000_0000_0001_0000 + 64'(i) * 64'h100;
                endcase
            end
        end else if (we) begin
            rf[waddr] <= wdata;
        end
    end

    typedef struct packed {
        logic [31:0] ins;
        logic [15:0] md;
        logic        ill;
        logic [1:0]  lat;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [0:NV-1] = '{
        '{ {6'd42, 5'd7,  5'd1,  16'h0010},                     16'h1234, 1'b0, 2'd0 }, // R1 R5
        '{ {6'd42, 5'd8,  5'd0,  16'hFFFE},                     16'h8000, 1'b0, 2'd1 }, // R4 R6
        '{ {6'd43, 5'd9,  5'd2,  16'h0021},                     16'hFF7F, 1'b0, 2'd2 }, // R7 R9
        '{ {6'd31, 5'd10, 5'd0,  5'd3, 10'd343, 1'b0},          16'h7FFF, 1'b0, 2'd0 }, // R2 R4
        '{ {6'd31, 5'd11, 5'd4,  5'd5, 10'd375, 1'b1},          16'hA55A, 1'b0, 2'd1 }, // R3 wrap
        '{ {6'd31, 5'd12, 5'd6,  5'd7, 10'd343, 1'b1},          16'h0001, 1'b0, 2'd3 }, // R2 Rc
        '{ {6'd40, 5'd13, 5'd1,  16'h0002},                     16'h1111, 1'b1, 2'd0 }, // R10
        '{ {6'd31, 5'd13, 5'd1,  5'd2, 10'd279, 1'b0},          16'h2222, 1'b1, 2'd0 }, // R10
        '{ {6'd43, 5'd13, 5'd0,  16'h0004},                     16'hC000, 1'b0, 2'd0 }, // R4 update r0
        '{ {6'd31, 5'd14, 5'd14, 5'd6, 10'd375, 1'b0},          16'h8001, 1'b0, 2'd1 }  // R8 collision
    };

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic run_op(input logic [31:0] ins, input logic [15:0] md, input logic ill, input int lat);
        logic [5:0]  opc = ins[31:26];
        logic [4:0]  rt = ins[25:21], ra = ins[20:16], rb = ins[15:11];
        logic        upd = (opc == 6'd43) || (opc == 6'd31 && ins[10:1] == 10'd375);
        logic        idx = (opc == 6'd31);
        logic [63:0] base, off, sum, expv;
        logic [31:0] ea;
        base = (!upd && ra == 5'd0) ? 64'd0 : rf[ra];
        off  = idx ? rf[rb] : {{48{ins[15]}}, ins[15:0]};
        sum  = base + off;
        ea   = sum[31:0];
        expv = {{48{md[15]}}, md};
        @(negedge clk); start = 1'b1; instr = ins;
        @(negedge clk); start = 1'b0;
        if (ill) begin
            chk(illegal === 1'b1, "R10 illegal flag", 64'(illegal), 64'd1);
            chk(!mem_req && !we, "R10 no access", {62'd0, mem_req, we}, 64'd0);
            @(negedge clk);
            chk(!illegal && !mem_req && !we, "R10 quiet after", {61'd0, illegal, mem_req, we}, 64'd0);
        end else begin
            chk(mem_req && mem_addr == ea, "R3/R9 address", 64'(mem_addr), 64'(ea));
            for (int k = 0; k < lat; k++) begin
                @(negedge clk);
                chk(mem_req && mem_addr == ea && !we, "R11 request held", 64'(mem_addr), 64'(ea));
            end
            rvalid = 1'b1; rdata = md;
            @(negedge clk); rvalid = 1'b0; rdata = 16'h0;
            chk(we && waddr == rt, "R1/R2 dest addr", 64'(waddr), 64'(rt));
            chk(wdata[15:8] == md[15:8], "R5 byte order", 64'(wdata[15:8]), 64'(md[15:8]));
            chk(wdata == expv, "R6 sign extend", wdata, expv);
            chk(done == !upd, "R11 done timing", 64'(done), 64'(!upd));
            if (upd) begin
                @(negedge clk);
                chk(we && waddr == ra && done, "R7 base write addr", 64'(waddr), 64'(ra));
                chk(wdata == {32'd0, ea}, "R7 base write data", wdata, {32'd0, ea});
            end
            @(negedge clk);
            chk(!mem_req && !we && !done, "R11 idle after", {61'd0, mem_req, we, done}, 64'd0);
            if (upd) chk(rf[ra] == {32'd0, ea}, "R8 base holds address", rf[ra], {32'd0, ea});
            if (!upd || rt != ra) chk(rf[rt] == expv, "R6 dest final", rf[rt], expv);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(!mem_req && !we && !done && !illegal, "R12 in reset", {60'd0, mem_req, we, done, illegal}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!mem_req && !we && !done && !illegal, "R12 after reset", {60'd0, mem_req, we, done, illegal}, 64'd0);

        for (int v = 0; v < NV; v++)
            run_op(VECS[v].ins, VECS[v].md, VECS[v].ill, int'(VECS[v].lat));

        // R11: a second start during an access is ignored
        @(negedge clk); start = 1'b1; instr = {6'd42, 5'd15, 5'd1, 16'h0000};
        @(negedge clk); start = 1'b0;
        chk(mem_req && mem_addr == 32'h0001_0100, "R11 first address", 64'(mem_addr), 64'h10100);
        start = 1'b1; instr = {6'd42, 5'd16, 5'd2, 16'h0040};
        @(negedge clk); start = 1'b0;
        chk(mem_req && mem_addr == 32'h0001_0100, "R11 start ignored", 64'(mem_addr), 64'h10100);
        rvalid = 1'b1; rdata = 16'h0042;
        @(negedge clk); rvalid = 1'b0;
        chk(we && waddr == 5'd15 && done, "R11 original dest", 64'(waddr), 64'd15);
        @(negedge clk);
        chk(!mem_req && !we, "R11 no queued op", {62'd0, mem_req, we}, 64'd0);
        chk(rf[16] == 64'h0001_1000, "R11 r16 untouched", rf[16], 64'h11000);

        // R12: reset while a request is outstanding
        @(negedge clk); start = 1'b1; instr = {6'd43, 5'd17, 5'd1, 16'h0002};
        @(negedge clk); start = 1'b0;
        chk(mem_req == 1'b1, "R12 request before reset", 64'(mem_req), 64'd1);
        rst_n = 1'b0;
        @(negedge clk);
        chk(!mem_req && !we && !done && !illegal, "R12 reset mid-op", {60'd0, mem_req, we, done, illegal}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!mem_req && !we, "R12 idle after release", {62'd0, mem_req, we}, 64'd0);

        if (!finished) begin
            finished = 1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_run++; n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule